// File: doc/BRIEF.md
# I2C Serial Memory Slave Controller

This block is the bus-facing half of an 8192 x 8 serial memory. It watches the I2C clock and data lines through a fast system clock, finds Start, repeated Start and Stop conditions, and decodes the select byte against a fixed type code and three chip-enable pins. It drives the data line only as an open-drain pull-down, through an output-enable signal.

A write command loads a 13-bit byte address from two address bytes. Each following data byte is handed to a page-write back end as an address and data pair with a one-cycle strobe. A Stop that comes in the slot right after a data acknowledge tells the back end to start its internal write cycle. Reads take bytes from a synchronous memory port that has one clock of latency. The same address counter serves current-address, random and sequential reads. While the back end reports busy, the controller ignores Start and does not acknowledge its select byte, so a master can poll on the acknowledge.

Top module: `i2c_mem_slave`

## Requirements
- R1: A falling data edge while the clock is high is a Start. A rising data edge while the clock is high is a Stop. Serial bits are taken on the rising clock edge, most significant bit first.
- R2: The first byte after a Start carries 1010 in bits 7:4, chip-enable bits in 3:1 that are compared with `chip_sel[2:0]` (bit 3 against `chip_sel[2]`), and the direction in bit 0 (1 = read). On a match the slave holds `sda_oe` high through the 9th clock. On a mismatch it gives no acknowledge and stays idle until the next Start.
- R3: A write select is followed by two address bytes, high byte first, and each one is acknowledged. Bits 15:13 of the address are ignored.
- R4: Each write data byte is acknowledged and reported by a one-cycle `wr_stb` with `wr_addr` and `wr_data`. After each byte only the low 5 address bits step, so the address wraps inside a 32-byte page.
- R5: `wr_commit` pulses once only for a Stop in the slot that follows a data-byte acknowledge. A Stop anywhere else gives no pulse.
- R6: A read select with no address phase returns the byte at the current counter. The counter steps by one after every byte that is output.
- R7: A random read is an address-loading write select, then a repeated Start with no Stop, then a read select. It returns the byte at the loaded address.
- R8: A master acknowledge after a read byte brings the next byte. The counter wraps from 8191 to 0. A master NoAck ends the transfer, and the slave then leaves the line released.
- R9: While `busy_i` is high, a Start is ignored and the select byte gets no acknowledge.
- R10: `sda_oe` changes only while the clock is low, except when a Start or Stop releases it.
- R11: A Start or Stop in the middle of a byte aborts the transaction. A Stop keeps the address counter that was already loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low |
| chip_sel | input | 3 | Chip-enable code that the select byte must match |
| busy_i | input | 1 | Back end is in its internal write cycle |
| wr_stb | output | 1 | One-cycle strobe for each received data byte |
| wr_addr | output | ADDR_W | Byte address of the strobed data |
| wr_data | output | 8 | Strobed data byte |
| wr_commit | output | 1 | Starts the back end's write cycle |
| rd_addr | output | ADDR_W | Current address counter, to the memory port |
| rd_data | input | 8 | Memory byte at rd_addr, one clock later |

## Verification
Two functions can fall on the same bus event: a Stop ends the transaction, and it may also start the write cycle. Which one applies depends only on how far the current byte had got when the Stop came. The bench sends Stops after a full data byte, after four bits of a data byte, and right after the address bytes, and counts `wr_commit` pulses against the count it expects for each case. A second meeting point is the read counter wrapping at the top of the array in the same byte where a master acknowledge asks for the next byte. The bench judges this by reading across address 8191 and comparing with its own memory model.

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        chip_sel,
  input  logic              busy_i,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data
);
  localparam int HI_W = ADDR_W - 8;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_ADH, S_ADL, S_WR,
    S_ACK_DEV, S_ACK_AH, S_ACK_AL, S_ACK_WR, S_RD, S_RACK
  } st_t;

  st_t              state;
  logic [2:0]       scl_p, sda_p;
  logic [3:0]       bitcnt;
  logic [7:0]       sr;
  logic [HI_W-1:0]  ahi;
  logic [ADDR_W-1:0] cnt;
  logic             rw, mack, wr_pend;

  wire scl_s   = scl_p[1];
  wire scl_q   = scl_p[2];
  wire sda_s   = sda_p[1];
  wire sda_q   = sda_p[2];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c  = scl_s & scl_q & ~sda_q & sda_s;
  wire rx      = (state == S_DEV) || (state == S_ADH) || (state == S_ADL) || (state == S_WR);
  wire got8    = (bitcnt == 4'd8);

  assign rd_addr = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      bitcnt    <= '0;
      sr        <= '0;
      ahi       <= '0;
      cnt       <= '0;
      rw        <= 1'b0;
      mack      <= 1'b0;
      wr_pend   <= 1'b0;
      sda_oe    <= 1'b0;
      wr_stb    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_commit <= 1'b0;
    end else begin
      wr_stb    <= 1'b0;
      wr_commit <= 1'b0;
      if (start_c) begin
        state   <= busy_i ? S_IDLE : S_DEV;
        bitcnt  <= '0;
        sda_oe  <= 1'b0;
        wr_pend <= 1'b0;
      end else if (stop_c) begin
        if (state == S_WR && bitcnt == 4'd1 && wr_pend) wr_commit <= 1'b1;
        state   <= S_IDLE;
        sda_oe  <= 1'b0;
        wr_pend <= 1'b0;
      end else if (state != S_IDLE) begin
        if (scl_rise) begin
          bitcnt <= bitcnt + 4'd1;
          if (rx) sr <= {sr[6:0], sda_s};
          if (state == S_RD && bitcnt == 4'd7) cnt <= cnt + ADDR_W'(1);
          if (state == S_RACK) mack <= ~sda_s;
        end else if (scl_fall) begin
          case (state)
            S_DEV: if (got8) begin
              if (sr[7:1] == {4'b1010, chip_sel} && !busy_i) begin
                sda_oe <= 1'b1;
                rw     <= sr[0];
                state  <= S_ACK_DEV;
              end else begin
                state  <= S_IDLE;
              end
            end
            S_ADH: if (got8) begin
              ahi    <= sr[HI_W-1:0];
              sda_oe <= 1'b1;
              state  <= S_ACK_AH;
            end
            S_ADL: if (got8) begin
              cnt    <= {ahi, sr};
              sda_oe <= 1'b1;
              state  <= S_ACK_AL;
            end
            S_WR: if (got8) begin
              wr_stb  <= 1'b1;
              wr_addr <= cnt;
              wr_data <= sr;
              cnt[PAGE_W-1:0] <= cnt[PAGE_W-1:0] + PAGE_W'(1);
              wr_pend <= 1'b1;
              sda_oe  <= 1'b1;
              state   <= S_ACK_WR;
            end
            S_ACK_DEV: begin
              bitcnt <= '0;
              if (rw) begin
                sr     <= rd_data;
                sda_oe <= ~rd_data[7];
                state  <= S_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= S_ADH;
              end
            end
            S_ACK_AH: begin bitcnt <= '0; sda_oe <= 1'b0; state <= S_ADL; end
            S_ACK_AL: begin bitcnt <= '0; sda_oe <= 1'b0; state <= S_WR;  end
            S_ACK_WR: begin bitcnt <= '0; sda_oe <= 1'b0; state <= S_WR;  end
            S_RD: begin
              if (got8) begin
                sda_oe <= 1'b0;
                state  <= S_RACK;
              end else begin
                sr     <= {sr[6:0], 1'b0};
                sda_oe <= ~sr[6];
              end
            end
            S_RACK: begin
              bitcnt <= '0;
              if (mack) begin
                sr     <= rd_data;
                sda_oe <= ~rd_data[7];
                state  <= S_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= S_IDLE;
              end
            end
            default: state <= S_IDLE;
          endcase
        end
      end
    end
  end

  p_oe_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_fall || start_c || stop_c) |=> $stable(sda_oe));

  p_page_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (rd_addr[ADDR_W-1:PAGE_W] == wr_addr[ADDR_W-1:PAGE_W] &&
                rd_addr[PAGE_W-1:0] == PAGE_W'(wr_addr[PAGE_W-1:0] + PAGE_W'(1))));

  p_read_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD && scl_rise && bitcnt == 4'd7) |=> rd_addr == ADDR_W'($past(rd_addr) + ADDR_W'(1)));

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && state == S_IDLE) |=> state == S_IDLE);

  p_stop_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (state == S_IDLE && !sda_oe));

  p_commit_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> (state == S_IDLE && !wr_stb));
endmodule

// File: tb/i2c_mem_slave_test.sv
module i2c_mem_slave_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wr_stb, wr_commit;
  logic [12:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic busy_i;
  wire sda_bus = sda_m & ~sda_oe;

  i2c_mem_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .chip_sel(3'b101), .busy_i(busy_i), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_commit(wr_commit), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int checks = 0, errors = 0, cyc = 0, busy_cnt = 0;
  int ncap = 0, pstart = 0, ov_n = 0, commits = 0, r10_bad = 0;
  bit done = 0;
  logic [12:0] cap_a [0:63];
  logic [7:0]  cap_d [0:63];
  logic [12:0] ov_a [0:63];
  logic [7:0]  ov_d [0:63];
  logic scl_d = 1'b1, oe_d = 1'b0;

  function automatic logic [7:0] pat(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  function automatic logic [7:0] memv(input logic [12:0] a);
    logic [7:0] v = pat(a);
    for (int i = 0; i < ov_n; i++) if (ov_a[i] == a) v = ov_d[i];
    return v;
  endfunction

  assign busy_i = (busy_cnt != 0);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rd_data <= memv(rd_addr);
    if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    if (wr_stb && ncap < 64) begin
      cap_a[ncap] = wr_addr;
      cap_d[ncap] = wr_data;
      ncap = ncap + 1;
    end
    if (wr_commit) begin
      commits = commits + 1;
      for (int i = pstart; i < ncap; i++) if (ov_n < 64) begin
        ov_a[ov_n] = cap_a[i];
        ov_d[ov_n] = cap_d[i];
        ov_n = ov_n + 1;
      end
      busy_cnt <= 300;
    end
    if (wr_stb || wr_commit) ;
    if (rst_n && scl_m && scl_d && sda_oe != oe_d) r10_bad = r10_bad + 1;
    scl_d <= scl_m;
    oe_d  <= sda_oe;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog R1 actual %0d cycles expected completion", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hp();
    repeat (6) @(negedge clk);
  endtask

  task automatic tx_start();
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
  endtask

  task automatic tx_stop();
    sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask

  task automatic tx_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0;
    end
    hp();
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0;
    end
    hp(); sda_m = 1'b1; hp(); scl_m = 1'b1; hp();
    ack = !sda_bus;
    scl_m = 1'b0; hp();
  endtask

  task automatic rx_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hp(); scl_m = 1'b1; hp(); b[i] = sda_bus; scl_m = 1'b0;
    end
    hp(); sda_m = !mack; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0; hp(); sda_m = 1'b1;
  endtask

  task automatic wait_idle();
    while (busy_i) @(negedge clk);
    hp();
  endtask

  logic ack;
  logic [7:0] b;
  int c0, n0, low_seen;

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0, "R2 reset sda_oe", sda_oe, 0);
    chk(wr_stb == 1'b0 && wr_commit == 1'b0, "R5 reset strobes", {wr_stb, wr_commit}, 0);

    for (int c = 0; c < 8; c++) begin
      tx_start();
      tx_byte({4'b1010, 3'(c), 1'b0}, ack);
      chk(ack == (c == 5), "R2 chip-enable sweep", ack, (c == 5));
      tx_stop();
    end
    tx_start();
    tx_byte({4'b1110, 3'b101, 1'b0}, ack);
    chk(!ack, "R2 wrong type code", ack, 0);
    tx_stop();

    n0 = ncap;
    tx_start();
    tx_byte(8'hAA, ack);
    tx_byte(8'hE1, ack); chk(ack, "R3 high address ack", ack, 1);
    tx_byte(8'h23, ack); chk(ack, "R3 low address ack", ack, 1);
    tx_byte(8'h5A, ack); chk(ack, "R4 data ack", ack, 1);
    tx_stop();
    hp();
    chk(ncap == n0 + 1, "R4 strobe count", ncap - n0, 1);
    chk(cap_a[n0] == 13'h0123, "R3 address bits 15:13 ignored", cap_a[n0], 13'h0123);
    chk(cap_d[n0] == 8'h5A, "R1 data sampled on rising clock", cap_d[n0], 8'h5A);
    chk(commits == 1, "R5 commit after data stop", commits, 1);
    pstart = ncap;

    tx_start();
    tx_byte(8'hAA, ack);
    chk(!ack, "R9 no ack while busy", ack, 0);
    tx_stop();
    wait_idle();
    tx_start();
    tx_byte(8'hAA, ack);
    chk(ack, "R9 ack after busy ends", ack, 1);
    tx_stop();

    tx_start();
    tx_byte(8'hAA, ack); tx_byte(8'h01, ack); tx_byte(8'h23, ack);
    tx_start();
    tx_byte(8'hAB, ack);
    chk(ack, "R7 read select ack", ack, 1);
    rx_byte(1'b0, b);
    chk(b == 8'h5A, "R7 random read", b, 8'h5A);
    tx_stop();

    tx_start();
    tx_byte(8'hAB, ack);
    rx_byte(1'b0, b);
    chk(b == memv(13'h0124), "R6 current address read", b, memv(13'h0124));
    tx_stop();

    n0 = ncap;
    tx_start();
    tx_byte(8'hAA, ack); tx_byte(8'h01, ack); tx_byte(8'hFE, ack);
    tx_byte(8'h11, ack); tx_byte(8'h22, ack); tx_byte(8'h33, ack); tx_byte(8'h44, ack);
    tx_stop();
    hp();
    chk(ncap == n0 + 4, "R4 page strobes", ncap - n0, 4);
    chk(cap_a[n0+1] == 13'h01FF, "R4 page step", cap_a[n0+1], 13'h01FF);
    chk(cap_a[n0+2] == 13'h01E0, "R4 page wrap", cap_a[n0+2], 13'h01E0);
    chk(cap_a[n0+3] == 13'h01E1 && cap_d[n0+3] == 8'h44, "R4 page last", cap_a[n0+3], 13'h01E1);
    chk(commits == 2, "R5 page commit", commits, 2);
    pstart = ncap;
    wait_idle();

    tx_start();
    tx_byte(8'hAA, ack); tx_byte(8'h01, ack); tx_byte(8'hE0, ack);
    tx_start(); tx_byte(8'hAB, ack);
    rx_byte(1'b1, b); chk(b == 8'h33, "R8 sequential first", b, 8'h33);
    rx_byte(1'b0, b); chk(b == 8'h44, "R8 sequential second", b, 8'h44);
    tx_stop();

    tx_start();
    tx_byte(8'hAA, ack); tx_byte(8'h1F, ack); tx_byte(8'hFE, ack);
    tx_start(); tx_byte(8'hAB, ack);
    rx_byte(1'b1, b); chk(b == memv(13'h1FFE), "R8 before wrap", b, memv(13'h1FFE));
    rx_byte(1'b1, b); chk(b == memv(13'h1FFF), "R8 last location", b, memv(13'h1FFF));
    rx_byte(1'b0, b); chk(b == memv(13'h0000), "R8 wrap to zero", b, memv(13'h0000));
    low_seen = 0;
    for (int i = 0; i < 9; i++) begin
      hp(); scl_m = 1'b1; hp(); if (!sda_bus) low_seen++; scl_m = 1'b0;
    end
    chk(low_seen == 0, "R8 released after NoAck", low_seen, 0);
    hp();
    tx_stop();

    c0 = commits;
    tx_start();
    tx_byte(8'hAA, ack); tx_byte(8'h02, ack); tx_byte(8'h00, ack);
    tx_byte(8'h77, ack);
    tx_bits(8'hF0, 4);
    tx_stop();
    hp();
    chk(commits == c0, "R5 mid-byte stop no commit", commits - c0, 0);
    pstart = ncap;

    tx_start();
    tx_byte(8'hAA, ack); tx_byte(8'h05, ack); tx_byte(8'h00, ack);
    tx_stop();
    hp();
    chk(commits == c0, "R5 address-only stop no commit", commits - c0, 0);
    tx_start();
    tx_byte(8'hAB, ack);
    rx_byte(1'b0, b);
    chk(b == memv(13'h0500), "R11 stop keeps counter", b, memv(13'h0500));
    tx_stop();

    tx_start();
    tx_bits(8'hA0, 3);
    tx_start();
    tx_byte(8'hAB, ack);
    chk(ack, "R11 start aborts partial byte", ack, 1);
    rx_byte(1'b0, b);
    chk(b == memv(13'h0501), "R11 read after abort", b, memv(13'h0501));
    tx_stop();

    chk(r10_bad == 0, "R10 output changes with clock low", r10_bad, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule